// File: doc/BRIEF.md
# UART Word Packet Grouper

This block sits behind one UART receive channel and collects the words it decodes into packets. Every accepted word is written into a small packet store first; the block then decides whether that word ends the packet. Two end conditions can be configured: a match word and a word count. Whichever is met first closes the packet, and the matching word is kept as the packet's final word. When both conditions are switched off, the block groups nothing: words are still taken from the input, but they are dropped and no packet is ever emitted.

On closing, the block pulses a completion strobe. With it come the packet length, a start timestamp and an end timestamp. The start timestamp is the stamp the receiver attached to the packet's first word, which is the time of that word's first data-bit sample. The end timestamp is read from the block's own free-running counter in the cycle the closing word is accepted. The packet's words then leave in arrival order on a valid/ready output stream, with a last marker on the final word.

While a packet drains, the input stream is held off with `in_ready` low, so a slow consumer applies back-pressure to the receiver. The output stream holds its word and last marker stable for as long as `out_valid` is high and `out_ready` is low. If the store fills before either end condition is met, the packet is closed by force and flagged. One instance serves one channel, so each direction has its own instance and its own configuration.

Top module: `word_packet_grouper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` and `pkt_done` are 0 and `in_ready` is 1.
- R2: When `cfg_delim_en` is 0 and `cfg_len` is 0, every offered word is accepted (`in_ready` stays 1) and discarded; `pkt_done` and `out_valid` stay 0.
- R3: With `cfg_delim_en` set, an accepted word equal to `cfg_delim` over all WORD_W bits (full 9-bit values included) closes the packet, and that word is the packet's last output word.
- R4: With `cfg_len` non-zero, the packet closes when the accepted word brings the count to `cfg_len`, and `pkt_len` equals `cfg_len`.
- R5: With both conditions enabled, the first one met closes the packet. A word that meets both at once closes it once.
- R6: `pkt_start_ts` equals the `in_ts` value presented with the packet's first word.
- R7: `pkt_end_ts` equals the free-running counter in the closing word's accept cycle. The counter reads 0 in the first cycle after reset is released and increases by 1 every cycle.
- R8: If DEPTH words are accepted with neither condition met, the packet closes with `pkt_len` = DEPTH and `pkt_ovf` = 1. For every other packet `pkt_ovf` is 0.
- R9: A closed packet is emitted on `out_valid`/`out_word` in arrival order, with `out_last` high only on its final word. While `out_valid` is high and `out_ready` is low, the word and the marker hold.
- R10: `pkt_done` is a one-cycle pulse in the cycle after the closing accept; `out_valid` rises in that same cycle. `in_ready` is 0 from then until the final word's handshake and is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_delim_en | input | 1 | Enables the match-word end condition |
| cfg_delim | input | WORD_W | Match word that ends a packet |
| cfg_len | input | CNT_W | Word count that ends a packet; 0 disables |
| in_valid | input | 1 | A received word is offered |
| in_ready | output | 1 | The block can take a word |
| in_word | input | WORD_W | Received word |
| in_ts | input | TS_W | Stamp of the word's first data-bit sample |
| out_valid | output | 1 | A packet word is presented |
| out_ready | input | 1 | The consumer takes the presented word |
| out_word | output | WORD_W | Packet word |
| out_last | output | 1 | Presented word is the packet's last |
| pkt_done | output | 1 | One-cycle packet-closed strobe |
| pkt_len | output | CNT_W | Word count of the last closed packet |
| pkt_start_ts | output | TS_W | Start stamp of the last closed packet |
| pkt_end_ts | output | TS_W | End stamp of the last closed packet |
| pkt_ovf | output | 1 | Last closed packet was forced closed by a full store |

## Verification
The assertions take the three configuration inputs to be stable while a packet is being collected or drained. Under that assumption, a bypass word can never close a packet, and a closed length can never exceed `cfg_len`. The stimulus changes configuration only after the previous packet has fully drained and no partial packet is held. It offers words with varying idle gaps and toggles `out_ready` pseudo-randomly, so the stall properties on the output stream are exercised while words are held.

// File: rtl/word_packet_grouper_pkg.sv
package word_packet_grouper_pkg;

  typedef enum logic {
    GS_COLLECT = 1'b0,
    GS_DRAIN   = 1'b1
  } grp_state_e;

  typedef struct packed {
    logic by_match;
    logic by_count;
    logic by_full;
  } close_cause_t;

endpackage

// File: rtl/pg_stamp_counter.sv
module pg_stamp_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now
);

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + TS_W'(1);
  end

endmodule

// File: rtl/pg_close_detect.sv
module pg_close_detect
  import word_packet_grouper_pkg::*;
#(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              cfg_delim_en,
  input  logic [WORD_W-1:0] cfg_delim,
  input  logic [CNT_W-1:0]  cfg_len,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  count_after,
  output logic              bypass,
  output close_cause_t      cause,
  output logic              close_now,
  output logic              forced
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  always_comb begin
    bypass         = !cfg_delim_en && (cfg_len == '0);
    cause.by_match = cfg_delim_en && (word == cfg_delim);
    cause.by_count = (cfg_len != '0) && (count_after == cfg_len);
    cause.by_full  = (count_after == FULL_CNT);
    close_now      = !bypass && (cause.by_match || cause.by_count || cause.by_full);
    forced         = cause.by_full && !cause.by_match && !cause.by_count;
  end

endmodule

// File: rtl/pg_word_store.sv
module pg_word_store #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 16,
  parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/word_packet_grouper.sv
module word_packet_grouper
  import word_packet_grouper_pkg::*;
#(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 16,
  parameter int TS_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_delim_en,
  input  logic [WORD_W-1:0]            cfg_delim,
  input  logic [$clog2(DEPTH+1)-1:0]   cfg_len,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [WORD_W-1:0]            in_word,
  input  logic [TS_W-1:0]              in_ts,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [WORD_W-1:0]            out_word,
  output logic                         out_last,
  output logic                         pkt_done,
  output logic [$clog2(DEPTH+1)-1:0]   pkt_len,
  output logic [TS_W-1:0]              pkt_start_ts,
  output logic [TS_W-1:0]              pkt_end_ts,
  output logic                         pkt_ovf
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  grp_state_e        state_q;
  logic [CNT_W-1:0]  wr_cnt_q;
  logic [AW-1:0]     rd_ptr_q;
  logic [TS_W-1:0]   first_ts_q;
  logic [TS_W-1:0]   now;

  logic              accept;
  logic              store_we;
  logic [CNT_W-1:0]  count_after;
  logic              bypass;
  close_cause_t      cause;
  logic              close_now;
  logic              forced;
  logic              final_word;
  logic              final_hs;
  logic [WORD_W-1:0] store_rdata;

  pg_stamp_counter #(.TS_W(TS_W)) u_stamp (
    .clk   (clk),
    .rst_n (rst_n),
    .now   (now)
  );

  assign in_ready    = (state_q == GS_COLLECT);
  assign accept      = in_valid && in_ready;
  assign count_after = wr_cnt_q + CNT_W'(1);
  assign store_we    = accept && !bypass;

  pg_close_detect #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
  ) u_close (
    .cfg_delim_en (cfg_delim_en),
    .cfg_delim    (cfg_delim),
    .cfg_len      (cfg_len),
    .word         (in_word),
    .count_after  (count_after),
    .bypass       (bypass),
    .cause        (cause),
    .close_now    (close_now),
    .forced       (forced)
  );

  pg_word_store #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH),
    .AW     (AW)
  ) u_store (
    .clk   (clk),
    .we    (store_we),
    .waddr (wr_cnt_q[AW-1:0]),
    .wdata (in_word),
    .raddr (rd_ptr_q),
    .rdata (store_rdata)
  );

  assign out_valid  = (state_q == GS_DRAIN);
  assign out_word   = store_rdata;
  assign final_word = (CNT_W'(rd_ptr_q) == (pkt_len - CNT_W'(1)));
  assign out_last   = out_valid && final_word;
  assign final_hs   = out_valid && out_ready && final_word;

  // collection and drain control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= GS_COLLECT;
      wr_cnt_q   <= '0;
      rd_ptr_q   <= '0;
      first_ts_q <= '0;
    end else begin
      unique case (state_q)
        GS_COLLECT: begin
          if (store_we) begin
            if (wr_cnt_q == '0) first_ts_q <= in_ts;
            if (close_now) begin
              state_q  <= GS_DRAIN;
              wr_cnt_q <= '0;
              rd_ptr_q <= '0;
            end else begin
              wr_cnt_q <= count_after;
            end
          end
        end
        GS_DRAIN: begin
          if (out_ready) begin
            if (final_hs) state_q <= GS_COLLECT;
            else          rd_ptr_q <= rd_ptr_q + AW'(1);
          end
        end
        default: state_q <= GS_COLLECT;
      endcase
    end
  end

  // packet descriptor, held until the next close
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_done     <= 1'b0;
      pkt_len      <= '0;
      pkt_start_ts <= '0;
      pkt_end_ts   <= '0;
      pkt_ovf      <= 1'b0;
    end else begin
      pkt_done <= store_we && close_now;
      if (store_we && close_now) begin
        pkt_len      <= count_after;
        pkt_start_ts <= (wr_cnt_q == '0) ? in_ts : first_ts_q;
        pkt_end_ts   <= now;
        pkt_ovf      <= forced;
      end
    end
  end

endmodule

// File: rtl/word_packet_grouper_chk.sv
module word_packet_grouper_chk #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_delim_en,
  input logic [CNT_W-1:0]  cfg_len,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              out_last,
  input logic              pkt_done,
  input logic [CNT_W-1:0]  pkt_len,
  input logic              pkt_ovf
);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  p_done_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> out_valid);

  p_hold_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));

  p_bypass_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cfg_delim_en && cfg_len == '0) |=> !pkt_done);

  p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && cfg_len != '0) |-> (pkt_len <= cfg_len));

  p_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len != '0 && pkt_len <= CNT_W'(DEPTH)));

  p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_ovf) |-> (pkt_len == CNT_W'(DEPTH)));

endmodule

bind word_packet_grouper word_packet_grouper_chk #(
  .WORD_W (WORD_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_delim_en (cfg_delim_en),
  .cfg_len      (cfg_len),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_word     (out_word),
  .out_last     (out_last),
  .pkt_done     (pkt_done),
  .pkt_len      (pkt_len),
  .pkt_ovf      (pkt_ovf)
);

// File: tb/sim_word_packet_grouper.sv
`timescale 1ns/1ps
module sim_word_packet_grouper;

  localparam int WORD_W = 9;
  localparam int DEPTH  = 16;
  localparam int TS_W   = 32;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_delim_en = 1'b0;
  logic [WORD_W-1:0] cfg_delim = '0;
  logic [CNT_W-1:0]  cfg_len = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [WORD_W-1:0] in_word = '0;
  logic [TS_W-1:0]   in_ts = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [WORD_W-1:0] out_word;
  logic              out_last;
  logic              pkt_done;
  logic [CNT_W-1:0]  pkt_len;
  logic [TS_W-1:0]   pkt_start_ts;
  logic [TS_W-1:0]   pkt_end_ts;
  logic              pkt_ovf;

  always #5 clk = ~clk;

  word_packet_grouper #(.WORD_W(WORD_W), .DEPTH(DEPTH), .TS_W(TS_W)) u0 (
    .clk (clk), .rst_n (rst_n),
    .cfg_delim_en (cfg_delim_en), .cfg_delim (cfg_delim), .cfg_len (cfg_len),
    .in_valid (in_valid), .in_ready (in_ready), .in_word (in_word), .in_ts (in_ts),
    .out_valid (out_valid), .out_ready (out_ready), .out_word (out_word),
    .out_last (out_last), .pkt_done (pkt_done), .pkt_len (pkt_len),
    .pkt_start_ts (pkt_start_ts), .pkt_end_ts (pkt_end_ts), .pkt_ovf (pkt_ovf)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [WORD_W-1:0] cur[$];
  logic [WORD_W-1:0] outq[$];
  logic [TS_W-1:0]   m_first_ts;
  longint            tcount = 0;
  bit                m_acc = 0;
  bit                m_done = 0;
  int                m_len = 0;
  logic [TS_W-1:0]   m_start = '0;
  logic [TS_W-1:0]   m_end = '0;
  bit                m_ovf = 0;
  string             m_tag = "R3";
  bit                cmp_on = 0;
  bit                bp_on = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      m_acc  = 0;
      m_done = 0;
      if (outq.size() != 0) begin
        if (out_ready) void'(outq.pop_front());
      end else if (in_valid) begin
        m_acc = 1;
        if (cfg_delim_en || cfg_len != 0) begin
          bit hd, hl, hf;
          cur.push_back(in_word);
          if (cur.size() == 1) m_first_ts = in_ts;
          hd = cfg_delim_en && (in_word == cfg_delim);
          hl = (cfg_len != 0) && (cur.size() == int'(cfg_len));
          hf = (cur.size() == DEPTH);
          if (hd || hl || hf) begin
            outq    = cur;
            m_len   = cur.size();
            cur     = {};
            m_done  = 1;
            m_start = m_first_ts;
            m_end   = TS_W'(tcount);
            m_ovf   = hf && !hd && !hl;
            if (m_ovf)                            m_tag = "R8";
            else if (cfg_delim_en && cfg_len != 0) m_tag = "R5";
            else if (hd)                          m_tag = "R3";
            else                                  m_tag = "R4";
          end
        end
      end
      tcount++;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      bit bypass;
      bypass = !cfg_delim_en && cfg_len == 0;
      chk("R10 in_ready", in_ready, outq.size() == 0);
      chk(bypass ? "R2 out_valid" : "R9 out_valid", out_valid, outq.size() != 0);
      if (outq.size() != 0) begin
        chk("R9 out_word", out_word, outq[0]);
        chk("R9 out_last", out_last, outq.size() == 1);
      end
      chk(bypass ? "R2 pkt_done" : "R10 pkt_done", pkt_done, m_done);
      if (m_done) begin
        chk({m_tag, " pkt_len"}, pkt_len, m_len);
        chk("R6 pkt_start_ts", pkt_start_ts, m_start);
        chk("R7 pkt_end_ts", pkt_end_ts, m_end);
        chk("R8 pkt_ovf", pkt_ovf, m_ovf);
      end
    end
    out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  logic [TS_W-1:0] ts_seed = 32'h100;

  task automatic send(input logic [WORD_W-1:0] w, input int gap);
    repeat (gap) @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    in_ts    = ts_seed;
    ts_seed  = ts_seed + 13;
    do @(negedge clk); while (!m_acc);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    while (outq.size() != 0 || m_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input bit den, input logic [WORD_W-1:0] d, input int len);
    cfg_delim_en = den;
    cfg_delim    = d;
    cfg_len      = CNT_W'(len);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset pkt_done", pkt_done, 0);
    chk("R1 reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset out_valid", out_valid, 0);
    chk("R1 post-reset in_ready", in_ready, 1);
    cmp_on = 1;

    // R2: bypass, both conditions off
    set_cfg(0, 9'h000, 0);
    for (int i = 0; i < 6; i++) send(WORD_W'(i + 5), i % 2);
    repeat (4) @(negedge clk);
    chk("R2 no packet after bypass words", out_valid, 0);

    // R3: match word only, full 9-bit match value
    set_cfg(1, 9'h1FF, 0);
    send(9'h011, 0); send(9'h1FE, 1); send(9'h100, 0); send(9'h1FF, 2);
    settle();
    send(9'h1FF, 0);
    settle();

    // R4: word count only
    set_cfg(0, 9'h000, 3);
    for (int i = 0; i < 9; i++) send(WORD_W'(9'h0A0 + i), i % 3);
    settle();

    // R5: both enabled, each winning in turn, then both at once
    bp_on = 1;
    set_cfg(1, 9'h00A, 5);
    send(9'h041, 0); send(9'h00A, 0);
    send(9'h001, 1); send(9'h002, 0); send(9'h003, 0); send(9'h004, 0); send(9'h005, 0);
    send(9'h031, 0); send(9'h032, 0); send(9'h033, 0); send(9'h034, 0); send(9'h00A, 0);
    settle();

    // R8: forced close on full store, and near-misses that are not overflow
    set_cfg(1, 9'h155, 20);
    for (int i = 0; i < DEPTH; i++) send(WORD_W'(i), 0);
    settle();
    for (int i = 0; i < DEPTH - 1; i++) send(WORD_W'(i + 32), i % 2);
    send(9'h155, 0);
    settle();
    set_cfg(0, 9'h000, DEPTH);
    for (int i = 0; i < DEPTH; i++) send(WORD_W'(9'h1F0 - i), 0);
    settle();

    // R6/R7/R9: mixed gaps under back-pressure
    set_cfg(1, 9'h0FF, 7);
    for (int i = 0; i < 40; i++) send((i % 9 == 8) ? 9'h0FF : WORD_W'(i * 11), i % 4);
    settle();
    bp_on = 0;
    repeat (5) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule